// File: doc/BRIEF.md
# Interlace-Capable Vertical Timing Generator

This block produces the vertical blanking and vertical sync levels for a raster display. It counts steps on strobes that arrive from the horizontal timing logic. In progressive mode, one step is taken per line, on the line-start strobe. In interlaced mode, the mid-line strobe also counts, so two steps are taken per line. Every start, stop and total value is programmed as the step of interest minus one. A level therefore changes on the step that leaves the programmed count, and the counter wraps on the step that leaves the programmed total.

Software writes the timing values into shadow registers through a single write strobe. A later write to the control register, with the update bit set, arms a pending flag. At the next field or frame boundary the whole shadow set moves into the working set in one step, and the flag clears itself. In interlaced mode, even fields draw their blank and sync windows from a separate register pair. A field flag tells the two fields apart, and a one-cycle pulse marks the first step of every field or frame.

Top module: `vert_timing_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `vblank`, `vsync`, `field_even` and `frame_start` are 0, and no update is pending.
- R2: In progressive mode only `line_start` advances the count; a `half_line` strobe leaves every output unchanged.
- R3: The count runs 0 to the working total (address 1, bits 10:0), then returns to 0. `frame_start` is high for exactly one cycle, in the cycle where the count has just become 0.
- R4: `vblank` sets on the step leaving count equal to the blank start field (bits 10:0) and clears on the step leaving count equal to the blank stop field (bits 26:16). When both are equal, the clear wins. Blank registers: odd set at address 2, even set at address 4.
- R5: `vsync` follows the same rule with the sync registers: odd set at address 3, even set at address 5, same field positions as R4.
- R6: The control register (address 0) bit 1 selects interlaced mode. In that mode `half_line` also advances the count, and `field_even` toggles at every wrap. In progressive mode `field_even` is 0.
- R7: In interlaced mode, the even-set registers drive `vblank` and `vsync` while `field_even` is 1, and the odd set drives them otherwise.
- R8: Writes to addresses 0 to 5 alter the working timing only at the first wrap after a control write with bit 0 set. Until then, outputs follow the previous values.
- R9: The pending update clears when it is applied. Shadow writes made after that point, with no new request, do not reach the working set at later wraps.
- R10: With an odd number of steps per field in interlaced mode, the step that raises `vsync` falls on a line-start strobe in one field and on a mid-line strobe in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Line-start strobe from horizontal timing |
| half_line | input | 1 | Mid-line strobe, counted only in interlaced mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| vblank | output | 1 | Vertical blanking level |
| vsync | output | 1 | Vertical sync level |
| field_even | output | 1 | 1 during even fields |
| frame_start | output | 1 | One-cycle pulse at the start of each field or frame |

## Verification
A wrong count appears within one step as a `vblank` or `vsync` edge on the wrong strobe. It also moves `frame_start` off its period, and every strobe is checked against a model built from the requirements. A stuck or misapplied pending flag changes window positions by the first wrap after the faulty write. A wrong field flag or register-set choice shows up as a misplaced sync edge in the very next field.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int LINE_W   = 11;
  localparam int STOP_LSB = 16;

  typedef struct packed {
    logic [LINE_W-1:0] stop;
    logic [LINE_W-1:0] start;
  } span_t;

  typedef struct packed {
    logic              interlace;
    logic [LINE_W-1:0] total;
    span_t             blank_o;
    span_t             sync_o;
    span_t             blank_e;
    span_t             sync_e;
  } cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int DEF_TOTAL = 11,
  parameter int DEF_BS    = 8,
  parameter int DEF_BE    = 11,
  parameter int DEF_SS    = 9,
  parameter int DEF_SE    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              boundary,
  output cfg_t              work,
  output logic              il_next
);
  localparam span_t DEF_B = '{stop: LINE_W'(DEF_BE), start: LINE_W'(DEF_BS)};
  localparam span_t DEF_S = '{stop: LINE_W'(DEF_SE), start: LINE_W'(DEF_SS)};
  localparam cfg_t DEF_CFG = '{interlace: 1'b0, total: LINE_W'(DEF_TOTAL),
                               blank_o: DEF_B, sync_o: DEF_S,
                               blank_e: DEF_B, sync_e: DEF_S};

  cfg_t  sh_q, work_q;
  logic  pend_q, req;
  span_t wr_span;

  wire unused_rsvd = ^{wr_data[DATA_W-1:STOP_LSB+LINE_W], wr_data[STOP_LSB-1:LINE_W]};

  assign wr_span = '{stop: wr_data[STOP_LSB +: LINE_W], start: wr_data[0 +: LINE_W]};
  assign req     = wr_en && (wr_addr == ADDR_W'(0)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= DEF_CFG;
      work_q <= DEF_CFG;
      pend_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(0): sh_q.interlace <= wr_data[1];
          ADDR_W'(1): sh_q.total     <= wr_data[LINE_W-1:0];
          ADDR_W'(2): sh_q.blank_o   <= wr_span;
          ADDR_W'(3): sh_q.sync_o    <= wr_span;
          ADDR_W'(4): sh_q.blank_e   <= wr_span;
          ADDR_W'(5): sh_q.sync_e    <= wr_span;
          default: ;
        endcase
      end
      if (boundary && pend_q) work_q <= sh_q;
      if (req)           pend_q <= 1'b1;
      else if (boundary) pend_q <= 1'b0;
    end
  end

  assign work    = work_q;
  assign il_next = (boundary && pend_q) ? sh_q.interlace : work_q.interlace;

  // R8: working set moves only at a boundary
  p_hold_midframe_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(boundary)) |-> $stable(work_q));
  // R9: an applied request is consumed
  p_pend_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(boundary && pend_q && !req)) |-> !pend_q);
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              half_line,
  input  logic              interlace,
  input  logic              il_next,
  input  logic [LINE_W-1:0] total,
  output logic              step,
  output logic              wrap,
  output logic [LINE_W-1:0] cnt,
  output logic              field,
  output logic              frame_start
);
  logic [LINE_W-1:0] cnt_q;
  logic              field_q, fs_q;

  assign step = line_start || (half_line && interlace);
  assign wrap = step && (cnt_q == total);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      field_q <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      fs_q <= wrap;
      if (wrap) begin
        cnt_q   <= '0;
        field_q <= il_next ? ~field_q : 1'b0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt         = cnt_q;
  assign field       = field_q;
  assign frame_start = fs_q;

  // R3: count stays within the programmed total
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst) cnt_q <= total);
  // R3: start pulse coincides with count zero
  p_fs_zero_r3: assert property (@(posedge clk) disable iff (rst) fs_q |-> (cnt_q == '0));
  // R6: field flag is 0 in progressive mode
  p_field_prog_r6: assert property (@(posedge clk) disable iff (rst) !interlace |-> !field_q);
  // R6: field flag changes only at a wrap
  p_field_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap)) |-> $stable(field_q));
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [LINE_W-1:0] cnt,
  input  span_t             span,
  output logic              level
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst)                           lvl_q <= 1'b0;
    else if (step && cnt == span.stop)  lvl_q <= 1'b0;
    else if (step && cnt == span.start) lvl_q <= 1'b1;
  end

  assign level = lvl_q;

  // R4/R5: a level only moves on a counted step
  p_edge_on_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(step)) |-> $stable(lvl_q));
endmodule

// File: rtl/vert_timing_gen.sv
module vert_timing_gen
  import vtg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int DEF_TOTAL = 11,
  parameter int DEF_BS    = 8,
  parameter int DEF_BE    = 11,
  parameter int DEF_SS    = 9,
  parameter int DEF_SE    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              half_line,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              vblank,
  output logic              vsync,
  output logic              field_even,
  output logic              frame_start
);
  localparam int N_WIN = 2;

  cfg_t              work;
  logic              il_next, step, wrap, field, even_sel;
  logic [LINE_W-1:0] cnt;
  span_t             win_span [N_WIN];
  logic [N_WIN-1:0]  win_lvl;

  vtg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_TOTAL(DEF_TOTAL),
    .DEF_BS(DEF_BS), .DEF_BE(DEF_BE), .DEF_SS(DEF_SS), .DEF_SE(DEF_SE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .boundary(wrap), .work(work), .il_next(il_next)
  );

  vtg_counter u_cnt (
    .clk(clk), .rst(rst), .line_start(line_start), .half_line(half_line),
    .interlace(work.interlace), .il_next(il_next), .total(work.total),
    .step(step), .wrap(wrap), .cnt(cnt), .field(field), .frame_start(frame_start)
  );

  assign even_sel    = work.interlace && field;
  assign win_span[0] = even_sel ? work.blank_e : work.blank_o;
  assign win_span[1] = even_sel ? work.sync_e  : work.sync_o;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    vtg_window u_win (
      .clk(clk), .rst(rst), .step(step), .cnt(cnt),
      .span(win_span[w]), .level(win_lvl[w])
    );
  end

  assign vblank     = win_lvl[0];
  assign vsync      = win_lvl[1];
  assign field_even = field;

  // R1: quiet outputs straight after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !(vblank || vsync || field_even || frame_start));
endmodule

// File: tb/test_vert_timing_gen.sv
module test_vert_timing_gen;
  logic        clk = 0;
  logic        rst = 1;
  logic        line_start = 0, half_line = 0, wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        vblank, vsync, field_even, frame_start;

  int n_chk = 0, n_fail = 0;
  string g_tag = "R1";

  // bench model state, index 0 odd set, 1 even set
  int w_tot, w_bs[2], w_be[2], w_ss[2], w_se[2]; bit w_il;
  int s_tot, s_bs[2], s_be[2], s_ss[2], s_se[2]; bit s_il;
  bit m_pend, m_field, m_blank, m_sync, m_fs;
  int m_cnt;
  int rise_kind[2];

  always #5 clk = ~clk;

  vert_timing_gen i_vert_timing_gen (
    .clk(clk), .rst(rst), .line_start(line_start), .half_line(half_line),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .vsync(vsync), .field_even(field_even), .frame_start(frame_start)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string why);
    check({g_tag, " R4"}, {why, " vblank"}, vblank, m_blank);
    check({g_tag, " R5"}, {why, " vsync"}, vsync, m_sync);
    check({g_tag, " R6"}, {why, " field_even"}, field_even, m_field);
    check({g_tag, " R3"}, {why, " frame_start"}, frame_start, m_fs);
  endtask

  task automatic model_defaults();
    w_tot = 11; w_il = 0;
    for (int i = 0; i < 2; i++) begin
      w_bs[i] = 8; w_be[i] = 11; w_ss[i] = 9; w_se[i] = 10;
    end
    s_tot = w_tot; s_il = 0; s_bs = w_bs; s_be = w_be; s_ss = w_ss; s_se = w_se;
    m_pend = 0; m_field = 0; m_blank = 0; m_sync = 0; m_fs = 0; m_cnt = 0;
  endtask

  task automatic do_write(input int addr, input int stop, input int start);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(addr);
    wr_data = (32'(stop) << 16) | 32'(start);
    @(negedge clk);
    wr_en = 0;
    case (addr)
      0: begin s_il = start[1]; if (start[0]) m_pend = 1; end
      1: s_tot = start;
      2: begin s_bs[0] = start; s_be[0] = stop; end
      3: begin s_ss[0] = start; s_se[0] = stop; end
      4: begin s_bs[1] = start; s_be[1] = stop; end
      5: begin s_ss[1] = start; s_se[1] = stop; end
      default: ;
    endcase
    m_fs = 0;
    check_all("after write");
  endtask

  task automatic strobe(input bit half);
    bit e, wrap, old_sync, f_before;
    @(negedge clk);
    line_start = !half; half_line = half;
    @(negedge clk);
    line_start = 0; half_line = 0;
    m_fs = 0;
    if (!half || w_il) begin
      e = w_il && m_field;
      f_before = m_field;
      old_sync = m_sync;
      if (m_cnt == w_be[e]) m_blank = 0; else if (m_cnt == w_bs[e]) m_blank = 1;
      if (m_cnt == w_se[e]) m_sync = 0;  else if (m_cnt == w_ss[e]) m_sync = 1;
      if (!old_sync && m_sync && w_il) rise_kind[f_before] = half;
      wrap = (m_cnt == w_tot);
      m_cnt = wrap ? 0 : m_cnt + 1;
      if (wrap) begin
        m_fs = 1;
        if (m_pend) begin
          w_tot = s_tot; w_il = s_il; w_bs = s_bs; w_be = s_be; w_ss = s_ss; w_se = s_se;
          m_pend = 0;
        end
        m_field = w_il ? !m_field : 1'b0;
      end
    end
    check_all(half ? "half strobe" : "line strobe");
    @(negedge clk);
    m_fs = 0;
    check({g_tag, " R3"}, "frame_start one cycle", frame_start, 0);
  endtask

  task automatic t_reset();
    g_tag = "R1";
    rst = 1;
    repeat (3) @(negedge clk);
    model_defaults();
    check_all("in reset");
    rst = 0;
    @(negedge clk);
    check_all("after reset");
  endtask

  task automatic t_default_frames();
    g_tag = "R3";
    for (int i = 0; i < 26; i++) strobe(0);
  endtask

  task automatic t_half_ignored();
    bit b, s, f;
    g_tag = "R2";
    for (int i = 0; i < 8; i++) begin
      b = vblank; s = vsync; f = field_even;
      strobe(1);
      check("R2", "vblank after half", vblank, b);
      check("R2", "vsync after half", vsync, s);
      check("R2", "field after half", field_even, f);
      strobe(0);
    end
  endtask

  task automatic t_deferred();
    g_tag = "R8";
    do_write(1, 0, 9);
    do_write(2, 9, 7);
    do_write(3, 1, 0);
    for (int i = 0; i < 5; i++) strobe(0);
    do_write(0, 0, 1);
    for (int i = 0; i < 26; i++) strobe(0);
    g_tag = "R9";
    do_write(2, 9, 4);
    do_write(3, 6, 5);
    for (int i = 0; i < 22; i++) strobe(0);
  endtask

  task automatic t_interlace();
    g_tag = "R6";
    do_write(1, 0, 8);
    do_write(2, 8, 6);
    do_write(3, 4, 2);
    do_write(4, 8, 6);
    do_write(5, 4, 2);
    do_write(0, 0, 3);
    rise_kind[0] = -1; rise_kind[1] = -1;
    for (int i = 0; i < 60; i++) strobe(i[0]);
    check("R10", "sync rise strobe kinds differ", int'(rise_kind[0] != rise_kind[1]), 1);
  endtask

  task automatic t_even_set();
    g_tag = "R7";
    do_write(4, 8, 5);
    do_write(5, 5, 3);
    do_write(0, 0, 3);
    for (int i = 0; i < 50; i++) strobe(i[0]);
  endtask

  task automatic t_back_prog();
    g_tag = "R5";
    do_write(1, 0, 9);
    do_write(3, 3, 3);
    do_write(0, 0, 1);
    for (int i = 0; i < 40; i++) strobe(i[0]);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_default_frames();
        t_half_ignored();
        t_deferred();
        t_interlace();
        t_even_set();
        t_back_prog();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule